// File: doc/BRIEF.md
# MMC card identification sequencer

This block runs the command line of an MMC/SD bus while the bus comes up. After reset it runs the bus clock in idle bursts with no command on the line. It then sends a fixed series of probe commands to an external command-frame transmitter. Each command is a 6-bit index and a 32-bit argument, passed over a valid/ready handshake. Replies come back from a response receiver as a valid strobe with the 32-bit register contents, or as a timeout strobe.

The probe order is SD first and then MMC. A go-idle command (CMD0) goes out with no reply expected. An interface-condition probe (CMD8) follows, then an application-command probe (CMD55). If either SD probe gets a reply, the device is an SD card. A CMD8 reply also shows that the card can use sector addressing. If neither probe gets a reply, the sequencer polls with the operating-condition command (CMD1). The CMD1 argument carries the access mode chosen by a configuration input, and the host's voltage window. A device that asks for sector addressing never leaves busy when byte mode is requested, so the mode input lets the system avoid that deadlock.

Busy replies lead to further CMD1 commands, and the voltage window alternates between attempts. If no device leaves busy, or CMD1 gets no reply at all, the sequencer posts a failure status code and starts again from the idle clock bursts. On success it pulses done and holds the device type, the access mode and the final register value.

Top module: `mmc_ident_seq`

## Requirements
- R1: After reset, and after every restart, `idle_clk_en` is high for N_BURSTS bursts of BURST_LEN clocks each, with BURST_GAP low clocks between bursts. `cmd_valid` stays low in that phase, and the first command follows it.
- R2: Commands go out in this order: index 0 with argument 0 (no reply awaited), then index 8 with argument 0x000001AA, then index 55 with argument 0. Index 1 is sent only if neither index 8 nor index 55 got a reply.
- R3: A reply to index 8 or to index 55 ends the run with a one-clock `done`, `dev_sd`=1, `ocr_out`=0, and `dev_sector`=1 exactly when index 8 was answered. No index 1 command is sent.
- R4: Every index 1 argument has bit 31, bits 28:24 and bits 6:0 at zero. Bits 30:29 are 2'b10 when `cfg_sector` is 1 and 2'b00 when it is 0. Bit 7 equals `cfg_low_volt`.
- R5: Index 1 attempts are counted from 0. Even attempts set bits 23:15 and clear bits 14:8 (window 0x00FF8000). Odd attempts set bits 23:8 (window 0x00FFFF00). A first attempt in sector mode without the low-voltage bit is therefore 0x40FF8000.
- R6: A reply to index 1 with bit 31 clear means busy, and index 1 is sent again. At most MAX_POLLS index 1 commands go out per round.
- R7: A reply to index 1 with bit 31 set gives a one-clock `done`, `dev_sd`=0, `ocr_out` equal to the reply, and `dev_sector`=1 exactly when reply bits 30:29 are 2'b10.
- R8: A reply is accepted only if `rsp_valid` arrives within RESP_WAIT clocks after the command handshake. A later reply counts as no reply. A `rsp_timeout` strobe ends the wait at once.
- R9: If index 1 gets no reply, or MAX_POLLS busy replies, the block pulses `no_dev` for one clock, sets `status_code` to 0x3B and restarts from the R1 phase with index 0.
- R10: `status_code` is 0x1B from reset until the first failure and 0x3B after it.
- R11: While `cmd_valid` is high and `cmd_ready` is low, `cmd_index` and `cmd_arg` do not change. Each handshake sends exactly one command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sector | input | 1 | 1 requests sector addressing in CMD1, 0 requests byte addressing |
| cfg_low_volt | input | 1 | Sets the 1.7–1.95 V bit in CMD1 |
| idle_clk_en | output | 1 | Bus clock runs with the command line idle |
| cmd_valid | output | 1 | Command frame offered to the transmitter |
| cmd_ready | input | 1 | Transmitter accepts the frame |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| rsp_valid | input | 1 | Reply received |
| rsp_timeout | input | 1 | Receiver gave up waiting for a reply |
| rsp_ocr | input | 32 | Reply register contents |
| done | output | 1 | One-clock pulse when a device is identified |
| dev_sd | output | 1 | 1 for an SD card, 0 for an MMC/eMMC device |
| dev_sector | output | 1 | Device uses sector addressing |
| ocr_out | output | 32 | Final operating-condition value (0 for SD) |
| no_dev | output | 1 | One-clock pulse when a round fails |
| status_code | output | 8 | 0x1B during normal probing, 0x3B after a failure |

## Verification
The checker assumes that the receiver raises `rsp_valid` or `rsp_timeout` only while a reply is pending, and that `cfg_sector` and `cfg_low_volt` change only while no index 1 command is waiting on the handshake. The device model in the bench answers only after it has accepted a command. It keeps `cmd_ready` low while it holds a reply back. It changes the mode input only during the idle burst that follows a failure. The sweep covers both configuration inputs and seven device behaviours. These include a reply on the last accepted clock and a reply one clock too late.

// File: rtl/mmc_ident_pkg.sv
package mmc_ident_pkg;

   typedef enum logic [1:0] {
      ST_BURST,
      ST_SEND,
      ST_WAIT,
      ST_DONE
   } seq_state_t;

   typedef enum logic [1:0] {
      PR_RESET,
      PR_IFCOND,
      PR_APPCMD,
      PR_OPCOND
   } probe_t;

   localparam logic [5:0]  IDX_RESET  = 6'd0;
   localparam logic [5:0]  IDX_IFCOND = 6'd8;
   localparam logic [5:0]  IDX_APPCMD = 6'd55;
   localparam logic [5:0]  IDX_OPCOND = 6'd1;

   localparam logic [31:0] IFCOND_ARG = 32'h0000_01AA;
   localparam logic [31:0] WIN_HIGH   = 32'h00FF_8000;
   localparam logic [31:0] WIN_WIDE   = 32'h00FF_FF00;
   localparam logic [31:0] LOWV_BIT   = 32'h0000_0080;

   localparam logic [1:0]  ACC_SECTOR = 2'b10;
   localparam logic [1:0]  ACC_BYTE   = 2'b00;

   localparam logic [7:0]  STAT_BOOT  = 8'h1B;
   localparam logic [7:0]  STAT_NODEV = 8'h3B;

   function automatic logic [5:0] probe_index(probe_t p);
      case (p)
         PR_RESET:  return IDX_RESET;
         PR_IFCOND: return IDX_IFCOND;
         PR_APPCMD: return IDX_APPCMD;
         default:   return IDX_OPCOND;
      endcase
   endfunction

endpackage

// File: rtl/mmc_idle_burst.sv
module mmc_idle_burst #(
   parameter int BURST_LEN = 100,
   parameter int BURST_GAP = 8,
   parameter int N_BURSTS  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick,
   output logic clk_en,
   output logic fin
);
   localparam int PERIOD = BURST_LEN + BURST_GAP;
   localparam int PW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;
   localparam int BW     = (N_BURSTS > 2) ? $clog2(N_BURSTS) : 1;
   localparam logic [PW-1:0] POS_LAST   = PW'(PERIOD - 1);
   localparam logic [PW-1:0] POS_ENDB   = PW'(BURST_LEN - 1);
   localparam logic [BW-1:0] BURST_LAST = BW'(N_BURSTS - 1);

   logic          active;
   logic [PW-1:0] pos;
   logic [BW-1:0] burst;

   assign clk_en = active && (pos <= POS_ENDB);
   assign fin    = active && (burst == BURST_LAST) && (pos == POS_ENDB);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b1;
         pos    <= '0;
         burst  <= '0;
      end else if (kick) begin
         active <= 1'b1;
         pos    <= '0;
         burst  <= '0;
      end else if (active) begin
         if (fin) begin
            active <= 1'b0;
         end else if (pos == POS_LAST) begin
            pos   <= '0;
            burst <= burst + 1'b1;
         end else begin
            pos <= pos + 1'b1;
         end
      end
   end
endmodule

// File: rtl/mmc_rsp_timer.sv
module mmc_rsp_timer #(
   parameter int RESP_WAIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int TW = (RESP_WAIT > 2) ? $clog2(RESP_WAIT) : 1;
   localparam logic [TW-1:0] CNT_LAST = TW'(RESP_WAIT - 1);

   logic [TW-1:0] cnt;

   assign expired = run && (cnt == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (!expired)   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/mmc_opcond_arg.sv
module mmc_opcond_arg
   import mmc_ident_pkg::*;
#(
   parameter bit ALT_WINDOW = 1'b1
) (
   input  logic        sector,
   input  logic        low_volt,
   input  logic        odd_try,
   output logic [31:0] arg
);
   logic [31:0] window;

   generate
      if (ALT_WINDOW) begin : g_alternate
         assign window = odd_try ? WIN_WIDE : WIN_HIGH;
      end else begin : g_fixed
         logic unused_odd;
         assign unused_odd = odd_try;
         assign window     = WIN_HIGH;
      end
   endgenerate

   assign arg = {1'b0, (sector ? ACC_SECTOR : ACC_BYTE), 29'd0}
              | window
              | (low_volt ? LOWV_BIT : 32'd0);
endmodule

// File: rtl/mmc_ident_seq.sv
module mmc_ident_seq
   import mmc_ident_pkg::*;
#(
   parameter int BURST_LEN  = 100,
   parameter int BURST_GAP  = 8,
   parameter int N_BURSTS   = 2,
   parameter int RESP_WAIT  = 64,
   parameter int MAX_POLLS  = 1000,
   parameter bit ALT_WINDOW = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_sector,
   input  logic        cfg_low_volt,
   output logic        idle_clk_en,
   output logic        cmd_valid,
   input  logic        cmd_ready,
   output logic [5:0]  cmd_index,
   output logic [31:0] cmd_arg,
   input  logic        rsp_valid,
   input  logic        rsp_timeout,
   input  logic [31:0] rsp_ocr,
   output logic        done,
   output logic        dev_sd,
   output logic        dev_sector,
   output logic [31:0] ocr_out,
   output logic        no_dev,
   output logic [7:0]  status_code
);
   localparam int AW = (MAX_POLLS > 2) ? $clog2(MAX_POLLS) : 1;
   localparam logic [AW-1:0] ATT_LAST = AW'(MAX_POLLS - 1);

   generate
      if (BURST_LEN < 2) begin : g_bad_len
         $error("BURST_LEN must be at least 2");
      end
      if (N_BURSTS < 1) begin : g_bad_bursts
         $error("N_BURSTS must be at least 1");
      end
      if (BURST_GAP < 0) begin : g_bad_gap
         $error("BURST_GAP must not be negative");
      end
      if (RESP_WAIT < 2) begin : g_bad_wait
         $error("RESP_WAIT must be at least 2");
      end
      if (MAX_POLLS < 1) begin : g_bad_polls
         $error("MAX_POLLS must be at least 1");
      end
   endgenerate

   seq_state_t    state;
   probe_t        probe;
   logic [AW-1:0] att;
   logic          sd_hint;

   logic          burst_fin;
   logic          burst_kick;
   logic          wait_expired;
   logic          resolved;
   logic          op_ready;
   logic          op_retry;
   logic          op_fail;
   logic [31:0]   op_arg;

   mmc_idle_burst #(
      .BURST_LEN (BURST_LEN),
      .BURST_GAP (BURST_GAP),
      .N_BURSTS  (N_BURSTS)
   ) i_burst (
      .clk    (clk),
      .rst_n  (rst_n),
      .kick   (burst_kick),
      .clk_en (idle_clk_en),
      .fin    (burst_fin)
   );

   mmc_rsp_timer #(
      .RESP_WAIT (RESP_WAIT)
   ) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state == ST_WAIT),
      .expired (wait_expired)
   );

   mmc_opcond_arg #(
      .ALT_WINDOW (ALT_WINDOW)
   ) i_arg (
      .sector   (cfg_sector),
      .low_volt (cfg_low_volt),
      .odd_try  (att[0]),
      .arg      (op_arg)
   );

   assign resolved   = (state == ST_WAIT) && (rsp_valid || rsp_timeout || wait_expired);
   assign op_ready   = rsp_valid && rsp_ocr[31];
   assign op_retry   = rsp_valid && !rsp_ocr[31] && (att != ATT_LAST);
   assign op_fail    = resolved && (probe == PR_OPCOND) && !op_ready && !op_retry;
   assign burst_kick = op_fail;

   assign cmd_valid  = (state == ST_SEND);
   assign cmd_index  = probe_index(probe);

   always_comb begin
      case (probe)
         PR_IFCOND: cmd_arg = IFCOND_ARG;
         PR_OPCOND: cmd_arg = op_arg;
         default:   cmd_arg = 32'd0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_BURST;
         probe       <= PR_RESET;
         att         <= '0;
         sd_hint     <= 1'b0;
         done        <= 1'b0;
         no_dev      <= 1'b0;
         dev_sd      <= 1'b0;
         dev_sector  <= 1'b0;
         ocr_out     <= 32'd0;
         status_code <= STAT_BOOT;
      end else begin
         done   <= 1'b0;
         no_dev <= 1'b0;
         case (state)
            ST_BURST: begin
               if (burst_fin) begin
                  state   <= ST_SEND;
                  probe   <= PR_RESET;
                  att     <= '0;
                  sd_hint <= 1'b0;
               end
            end
            ST_SEND: begin
               if (cmd_ready) begin
                  if (probe == PR_RESET) probe <= PR_IFCOND;
                  else                   state <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (resolved) begin
                  case (probe)
                     PR_IFCOND: begin
                        sd_hint <= rsp_valid;
                        probe   <= PR_APPCMD;
                        state   <= ST_SEND;
                     end
                     PR_APPCMD: begin
                        if (rsp_valid || sd_hint) begin
                           state      <= ST_DONE;
                           done       <= 1'b1;
                           dev_sd     <= 1'b1;
                           dev_sector <= sd_hint;
                           ocr_out    <= 32'd0;
                        end else begin
                           probe <= PR_OPCOND;
                           att   <= '0;
                           state <= ST_SEND;
                        end
                     end
                     PR_OPCOND: begin
                        if (op_ready) begin
                           state      <= ST_DONE;
                           done       <= 1'b1;
                           dev_sd     <= 1'b0;
                           dev_sector <= (rsp_ocr[30:29] == ACC_SECTOR);
                           ocr_out    <= rsp_ocr;
                        end else if (op_retry) begin
                           att   <= att + 1'b1;
                           state <= ST_SEND;
                        end else begin
                           state       <= ST_BURST;
                           no_dev      <= 1'b1;
                           status_code <= STAT_NODEV;
                        end
                     end
                     default: state <= ST_SEND;
                  endcase
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/mmc_ident_chk.sv
module mmc_ident_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cfg_sector,
   input logic        cfg_low_volt,
   input logic        idle_clk_en,
   input logic        cmd_valid,
   input logic        cmd_ready,
   input logic [5:0]  cmd_index,
   input logic [31:0] cmd_arg,
   input logic        done,
   input logic        dev_sd,
   input logic [31:0] ocr_out,
   input logic        no_dev,
   input logic [7:0]  status_code
);
   assert_quiet_during_burst_R1: assert property (@(posedge clk) disable iff (!rst_n)
      idle_clk_en |-> !cmd_valid);

   assert_reset_arg_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_index == 6'd0) |-> (cmd_arg == 32'd0));

   assert_opcond_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_index == 6'd1) |->
         (cmd_arg[31] == 1'b0 && cmd_arg[28:24] == 5'd0 && cmd_arg[6:0] == 7'd0 &&
          cmd_arg[30:29] == (cfg_sector ? 2'b10 : 2'b00) && cmd_arg[7] == cfg_low_volt));

   assert_opcond_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_index == 6'd1) |->
         (cmd_arg[23:8] == 16'hFF80 || cmd_arg[23:8] == 16'hFFFF));

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_mmc_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !dev_sd) |-> ocr_out[31]);

   assert_nodev_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
      no_dev |-> (status_code == 8'h3B && !done && idle_clk_en));

   assert_status_codes_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (status_code == 8'h1B) || (status_code == 8'h3B));

   assert_cmd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=>
         (cmd_valid && $stable(cmd_index) && $stable(cmd_arg)));
endmodule

bind mmc_ident_seq mmc_ident_chk i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_sector   (cfg_sector),
   .cfg_low_volt (cfg_low_volt),
   .idle_clk_en  (idle_clk_en),
   .cmd_valid    (cmd_valid),
   .cmd_ready    (cmd_ready),
   .cmd_index    (cmd_index),
   .cmd_arg      (cmd_arg),
   .done         (done),
   .dev_sd       (dev_sd),
   .ocr_out      (ocr_out),
   .no_dev       (no_dev),
   .status_code  (status_code)
);

// File: tb/test_mmc_ident_seq.sv
`timescale 1ns/100ps
module test_mmc_ident_seq;
   localparam int BL = 5;
   localparam int BG = 3;
   localparam int NB = 2;
   localparam int RW = 6;
   localparam int MP = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_sector = 1'b0;
   logic        cfg_low_volt = 1'b0;
   logic        idle_clk_en;
   logic        cmd_valid;
   logic        cmd_ready;
   logic [5:0]  cmd_index;
   logic [31:0] cmd_arg;
   logic        rsp_valid;
   logic        rsp_timeout;
   logic [31:0] rsp_ocr;
   logic        done;
   logic        dev_sd;
   logic        dev_sector;
   logic [31:0] ocr_out;
   logic        no_dev;
   logic [7:0]  status_code;

   int errs = 0;
   int checks = 0;
   int cyc = 0;
   int kind = 0;
   int n1 = 0;
   int rec_n = 0;
   logic [5:0]  rec_idx [0:63];
   logic [31:0] rec_arg [0:63];
   int          rec_cyc [0:63];
   int exp_n = 0;
   logic [5:0]  exp_idx [0:63];
   logic [31:0] exp_arg [0:63];

   int en_hi = 0, en_lo = 0, snap_hi = 0, snap_lo = 0;
   bit seen_cmd = 0;
   int done_cnt = 0, nodev_cnt = 0;
   logic cap_sd, cap_sector;
   logic [31:0] cap_ocr;
   logic [7:0]  nodev_stat;

   always #2.5 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   mmc_ident_seq #(
      .BURST_LEN (BL), .BURST_GAP (BG), .N_BURSTS (NB),
      .RESP_WAIT (RW), .MAX_POLLS (MP), .ALT_WINDOW (1'b1)
   ) i_mmc_ident_seq (
      .clk (clk), .rst_n (rst_n), .cfg_sector (cfg_sector), .cfg_low_volt (cfg_low_volt),
      .idle_clk_en (idle_clk_en), .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
      .cmd_index (cmd_index), .cmd_arg (cmd_arg), .rsp_valid (rsp_valid),
      .rsp_timeout (rsp_timeout), .rsp_ocr (rsp_ocr), .done (done), .dev_sd (dev_sd),
      .dev_sector (dev_sector), .ocr_out (ocr_out), .no_dev (no_dev),
      .status_code (status_code)
   );

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h (kind %0d sector %0b lowv %0b)",
                  what, act, expv, kind, cfg_sector, cfg_low_volt);
      end
   endtask

   function automatic logic [31:0] op_arg(input bit s, input bit l, input int att);
      return {1'b0, (s ? 2'b10 : 2'b00), 29'd0}
           | ((att % 2 == 1) ? 32'h00FF_FF00 : 32'h00FF_8000)
           | (l ? 32'h80 : 32'h0);
   endfunction

   function automatic logic [31:0] ready_ocr(input logic [1:0] mode);
      return {1'b1, mode, 5'd0, 24'hFF_8080};
   endfunction

   // device model: decides the reply to each accepted command
   task automatic decide(input logic [5:0] idx, input logic [31:0] arg,
                         output int rt, output int dl, output logic [31:0] oc);
      rt = 0; dl = 1; oc = {8'd0, 24'hFF_8080};
      if (idx == 6'd8) begin
         oc = 32'h1AA;
         if (kind == 0) rt = 1;
         else if (kind == 4) rt = 2;
         else if (kind == 5) begin rt = 1; dl = RW + 1; end
         else if (kind == 6) begin rt = 1; dl = RW; end
      end else if (idx == 6'd55) begin
         oc = 32'h120;
         if (kind == 0 || kind == 1) rt = 1;
         else if (kind == 4) rt = 2;
      end else if (idx == 6'd1) begin
         n1++;
         if (kind == 2) begin rt = 1; if (n1 > 2) oc = ready_ocr(arg[30:29]); end
         else if (kind == 3) begin rt = 1; if (arg[30:29] == 2'b10) oc = ready_ocr(arg[30:29]); end
         else if (kind == 5) begin rt = 1; oc = ready_ocr(arg[30:29]); end
      end
   endtask

   initial begin
      cmd_ready = 1'b0; rsp_valid = 1'b0; rsp_timeout = 1'b0; rsp_ocr = 32'd0;
      forever begin
         @(negedge clk);
         rsp_valid = 1'b0; rsp_timeout = 1'b0; cmd_ready = 1'b0;
         if (rst_n && cmd_valid) begin
            int rt, dl;
            logic [31:0] oc;
            if (rec_n < 64) begin
               rec_idx[rec_n] = cmd_index; rec_arg[rec_n] = cmd_arg; rec_cyc[rec_n] = cyc;
               rec_n++;
            end
            cmd_ready = 1'b1;
            decide(cmd_index, cmd_arg, rt, dl, oc);
            if (rt != 0) begin
               @(negedge clk);
               cmd_ready = 1'b0;
               repeat (dl - 1) @(negedge clk);
               if (rt == 1) begin rsp_valid = 1'b1; rsp_ocr = oc; end
               else rsp_timeout = 1'b1;
            end
         end
      end
   end

   // port monitor
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n) begin
            if (no_dev) begin
               nodev_cnt++; nodev_stat = status_code;
               seen_cmd = 0; en_hi = 0; en_lo = 0;
            end
            if (!seen_cmd) begin
               if (idle_clk_en) en_hi++;
               else if (!cmd_valid) en_lo++;
               if (cmd_valid) begin seen_cmd = 1; snap_hi = en_hi; snap_lo = en_lo; end
            end
            if (done) begin
               done_cnt++; cap_sd = dev_sd; cap_sector = dev_sector; cap_ocr = ocr_out;
            end
         end
      end
   end

   task automatic push(input logic [5:0] i, input logic [31:0] a);
      exp_idx[exp_n] = i; exp_arg[exp_n] = a; exp_n++;
   endtask

   task automatic push_sd_probes();
      push(6'd0, 32'd0); push(6'd8, 32'h1AA); push(6'd55, 32'd0);
   endtask

   task automatic wait_for(input int which, input int target);
      int g = 0;
      while (g < 4000 && ((which == 0) ? done_cnt : (which == 1) ? nodev_cnt : rec_n) < target) begin
         @(negedge clk); g++;
      end
   endtask

   task automatic compare_seq(input string tag);
      chk(rec_n == exp_n, {tag, " command count"}, rec_n, exp_n);
      for (int i = 0; i < exp_n && i < rec_n; i++) begin
         chk(rec_idx[i] == exp_idx[i], {tag, " command index"}, {26'd0, rec_idx[i]}, {26'd0, exp_idx[i]});
         chk(rec_arg[i] == exp_arg[i], {tag, " command argument"}, rec_arg[i], exp_arg[i]);
      end
   endtask

   task automatic run(input int k, input bit s, input bit l);
      kind = k; cfg_sector = s; cfg_low_volt = l;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rec_n = 0; exp_n = 0; n1 = 0; done_cnt = 0; nodev_cnt = 0;
      en_hi = 0; en_lo = 0; seen_cmd = 0; snap_hi = 0; snap_lo = 0;
      chk(status_code == 8'h1B && !cmd_valid && !done && !no_dev, "R10 reset state",
          {24'd0, status_code}, 32'h1B);
      rst_n = 1'b1;
      push_sd_probes();
      case (k)
         0, 6: begin
            wait_for(0, 1);
            chk(done_cnt == 1 && cap_sd && cap_sector && cap_ocr == 0, "R3 SD v2 result",
                {cap_ocr[29:0], cap_sd, cap_sector}, 32'h3);
            compare_seq("R2 R3 SD order");
         end
         1: begin
            wait_for(0, 1);
            chk(done_cnt == 1 && cap_sd && !cap_sector && cap_ocr == 0, "R3 SD v1 result",
                {cap_ocr[29:0], cap_sd, cap_sector}, 32'h2);
            compare_seq("R2 R3 SD order");
            if (rec_n >= 3) chk(rec_cyc[2] - rec_cyc[1] == RW + 1, "R8 wait length",
                                rec_cyc[2] - rec_cyc[1], RW + 1);
         end
         2: begin
            wait_for(0, 1);
            for (int a = 0; a < 3; a++) push(6'd1, op_arg(s, l, a));
            compare_seq("R5 R6 busy polling");
            chk(done_cnt == 1 && !cap_sd && cap_sector == s, "R7 MMC type", {30'd0, cap_sd, cap_sector}, {31'd0, s});
            chk(cap_ocr == ready_ocr(s ? 2'b10 : 2'b00), "R7 final OCR", cap_ocr, ready_ocr(s ? 2'b10 : 2'b00));
         end
         3: begin
            if (!s) begin
               wait_for(1, 1);
               for (int a = 0; a < MP; a++) push(6'd1, op_arg(0, l, a));
               chk(nodev_cnt == 1 && nodev_stat == 8'h3B, "R9 failure status", {24'd0, nodev_stat}, 32'h3B);
               cfg_sector = 1'b1;
               push_sd_probes();
               push(6'd1, op_arg(1, l, 0));
               wait_for(0, 1);
               compare_seq("R4 R6 R9 byte-mode deadlock and restart");
               chk(status_code == 8'h3B, "R10 status after failure", {24'd0, status_code}, 32'h3B);
            end else begin
               wait_for(0, 1);
               push(6'd1, op_arg(1, l, 0));
               compare_seq("R4 sector-mode first try");
            end
            chk(done_cnt == 1 && !cap_sd && cap_sector, "R7 sector device", {30'd0, cap_sd, cap_sector}, 32'h1);
         end
         4: begin
            wait_for(1, 1);
            wait_for(2, 5);
            push(6'd1, op_arg(s, l, 0));
            push(6'd0, 32'd0);
            compare_seq("R9 no reply restart");
            chk(nodev_cnt == 1 && done_cnt == 0 && nodev_stat == 8'h3B, "R9 no device",
                {24'd0, nodev_stat}, 32'h3B);
            if (rec_n >= 3) chk(rec_cyc[2] - rec_cyc[1] == 2, "R8 timeout strobe",
                                rec_cyc[2] - rec_cyc[1], 2);
         end
         default: begin
            wait_for(0, 1);
            push(6'd1, op_arg(s, l, 0));
            compare_seq("R8 R11 late reply ignored");
            chk(done_cnt == 1 && !cap_sd && cap_sector == s, "R8 late reply MMC path",
                {30'd0, cap_sd, cap_sector}, {31'd0, s});
         end
      endcase
      chk(snap_hi == NB * BL, "R1 burst clocks", snap_hi, NB * BL);
      chk(snap_lo == (NB - 1) * BG, "R1 burst gap", snap_lo, (NB - 1) * BG);
      if (k != 4 && !(k == 3 && !s))
         chk(status_code == 8'h1B, "R10 status kept", {24'd0, status_code}, 32'h1B);
      repeat (3) @(negedge clk);
      chk(done_cnt == (k == 4 ? 0 : 1), "R7 single done pulse", done_cnt, (k == 4 ? 0 : 1));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      for (int k = 0; k < 7; k++)
         for (int sl = 0; sl < 4; sl++)
            run(k, sl[1], sl[0]);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule